// File: doc/BRIEF.md
# Compare and Status Flag Unit

This block carries out the three compare operations of an 8-bit microcontroller core: register against register, register against register with the incoming carry chained in, and register against an 8-bit constant carried in the instruction word. It subtracts the second operand from the first and sets the arithmetic status flags from the difference. No result is written to any register. Only the status byte changes.

The core presents the instruction word, the two operand bytes read from its register file, and the current status byte, together with a valid strobe. The unit decodes the register indices straight from the instruction word, so the register file can be read in the same cycle. The updated status byte appears one clock later with an output strobe. Words that are not compares pass the status byte through unchanged.

The carry-chained form feeds the previous borrow into the subtraction. It can only clear the zero flag, never set it. A multi-byte compare is therefore issued low byte first and then chained upward, and it ends with Z and C describing the whole multi-byte value.

Top module: `cmp_flag_unit`

## Requirements
- R1: A word whose bits 15:10 are 000101 is a plain compare. It subtracts `rr_val` from `rd_val` with no borrow in, and `out_upd` is 1 for it.
- R2: A word whose bits 15:10 are 000001 is a chained compare. It subtracts `rr_val` and the incoming C (status bit 0) from `rd_val`.
- R3: A word whose bits 15:12 are 0011 is an immediate compare. Its constant is {bits 11:8, bits 3:0}, it replaces `rr_val` (which is then ignored), and no borrow comes in.
- R4: After a compare, C (bit 0) is 1 when the unsigned subtrahend plus the incoming borrow exceeds the minuend. H (bit 5) is the borrow out of bit 3.
- R5: After a compare, N (bit 2) is bit 7 of the difference, V (bit 3) is two's-complement overflow of the subtraction, and S (bit 4) is N XOR V.
- R6: After a plain or immediate compare, Z (bit 1) is 1 exactly when the difference is zero.
- R7: After a chained compare, Z is 0 when the difference is non-zero, and otherwise equals the incoming Z.
- R8: T (bit 6) and I (bit 7) of `sreg_out` always equal those of the accepted `sreg_in`.
- R9: Any word that is not one of the three compares gives `sreg_out` equal to `sreg_in`, with `out_upd` 0.
- R10: `out_valid` is 1 exactly in the cycle after `in_valid` was 1. When `in_valid` is 0, `sreg_out` holds its last value.
- R11: `dst_idx` is {bit 8, bits 7:4} for plain and chained compares and 16 + bits 7:4 for the immediate compare. `src_idx` is {bit 9, bits 3:0}. Both are combinational from `instr`.
- R12: While `rst` is high at a clock edge, `out_valid`, `out_upd` and `sreg_out` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| rd_val | input | 8 | First operand (minuend) from the register file |
| rr_val | input | 8 | Second operand from the register file |
| sreg_in | input | 8 | Current status byte |
| dst_idx | output | 5 | Decoded index of the minuend register |
| src_idx | output | 5 | Decoded index of the subtrahend register |
| out_valid | output | 1 | Registered strobe for `sreg_out` |
| out_upd | output | 1 | The accepted word was a compare |
| sreg_out | output | 8 | Updated status byte |

## Verification
The bench goes after three groups of corner cases.

- **Z in the chained compare.** A zero difference with the incoming Z clear must leave Z clear. A unit that recomputes Z from scratch would report a false equality in a multi-byte compare whose low bytes differ.
- **Borrow boundaries.** These are equal operands with carry in, 0x00 minus 0xFF, and 0x80 minus 0x01. Here a carry that ignores the incoming borrow, or an H tapped from the wrong bit, shows up directly.
- **Decoding.** Immediate compares are sent with a decoy `rr_val` and must ignore it. Non-compare words must leave every status bit alone. A unit that took the register operand, or that rewrote the flags on any word, would fail these checks.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;
  localparam int unsigned SR_C = 0;
  localparam int unsigned SR_Z = 1;
  localparam int unsigned SR_N = 2;
  localparam int unsigned SR_V = 3;
  localparam int unsigned SR_S = 4;
  localparam int unsigned SR_H = 5;
  localparam int unsigned SR_T = 6;
  localparam int unsigned SR_I = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CMP  = 2'd1,
    OP_CMPC = 2'd2,
    OP_CMPI = 2'd3
  } cmp_op_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/cmp_decode.sv
module cmp_decode
  import cmp_flag_pkg::*;
#(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output cmp_op_e            op,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [IDX_W-1:0]   src_idx,
  output logic [DATA_W-1:0]  imm
);
  localparam int unsigned NIB      = DATA_W / 2;
  localparam int unsigned TOP6_LSB = INSTR_W - 6;
  localparam int unsigned TOP4_LSB = INSTR_W - 4;
  localparam int unsigned DHI_BIT  = 8;
  localparam int unsigned RHI_BIT  = 9;

  logic [5:0] top6;
  logic [3:0] top4;

  assign top6 = instr[INSTR_W-1:TOP6_LSB];
  assign top4 = instr[INSTR_W-1:TOP4_LSB];

  always_comb begin
    if (top6 == 6'b000101)      op = OP_CMP;
    else if (top6 == 6'b000001) op = OP_CMPC;
    else if (top4 == 4'b0011)   op = OP_CMPI;
    else                        op = OP_NONE;
  end

  assign imm = {instr[2*NIB+NIB-1:2*NIB], instr[NIB-1:0]};

  always_comb begin
    if (op == OP_CMPI) dst_idx = {1'b1, instr[2*NIB-1:NIB]};
    else               dst_idx = {instr[DHI_BIT], instr[2*NIB-1:NIB]};
  end

  assign src_idx = {instr[RHI_BIT], instr[NIB-1:0]};

  always_comb begin
    if (op == OP_CMPI)
      assert (dst_idx >= IDX_W'(16)) else $error("AST_IMM_UPPER_BANK"); // R11
  end
endmodule

// File: rtl/cmp_sub.sv
module cmp_sub #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              bin,
  output logic [DATA_W-1:0] diff,
  output logic              bout,
  output logic              half_bout,
  output logic              ovf
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W:0] bw;
  assign bw[0] = bin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign diff[i]  = a[i] ^ b[i] ^ bw[i];
    assign bw[i+1]  = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & bw[i]);
  end

  assign bout      = bw[DATA_W];
  assign half_bout = bw[HALF];
  assign ovf = (a[DATA_W-1] & ~b[DATA_W-1] & ~diff[DATA_W-1]) |
               (~a[DATA_W-1] & b[DATA_W-1] & diff[DATA_W-1]);

  logic [DATA_W:0] ref_full;
  always_comb begin
    ref_full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
    assert (ref_full[DATA_W] == bout && ref_full[DATA_W-1:0] == diff)
      else $error("AST_BORROW_MATCH"); // R4
  end
endmodule

// File: rtl/cmp_flag_merge.sv
module cmp_flag_merge
  import cmp_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  cmp_op_e           op,
  input  logic [DATA_W-1:0] diff,
  input  logic              bout,
  input  logic              half_bout,
  input  logic              ovf,
  input  logic [7:0]        sreg_in,
  output logic [7:0]        sreg_next,
  output logic              upd
);
  arith_flags_t fl;
  logic         zero;

  assign zero = (diff == '0);
  assign upd  = (op != OP_NONE);

  always_comb begin
    fl.c = bout;
    fl.h = half_bout;
    fl.n = diff[DATA_W-1];
    fl.v = ovf;
    fl.s = diff[DATA_W-1] ^ ovf;
    fl.z = zero & ((op != OP_CMPC) | sreg_in[SR_Z]);
  end

  always_comb begin
    sreg_next = sreg_in;
    if (upd) begin
      sreg_next[SR_C] = fl.c;
      sreg_next[SR_Z] = fl.z;
      sreg_next[SR_N] = fl.n;
      sreg_next[SR_V] = fl.v;
      sreg_next[SR_S] = fl.s;
      sreg_next[SR_H] = fl.h;
    end
  end

  always_comb begin
    if (op == OP_CMPC && !sreg_in[SR_Z])
      assert (!sreg_next[SR_Z]) else $error("AST_CHAIN_Z_STICKY"); // R7
  end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  rd_val,
  input  logic [DATA_W-1:0]  rr_val,
  input  logic [7:0]         sreg_in,
  output logic [IDX_W-1:0]   dst_idx,
  output logic [IDX_W-1:0]   src_idx,
  output logic               out_valid,
  output logic               out_upd,
  output logic [7:0]         sreg_out
);
  cmp_op_e           op;
  logic [DATA_W-1:0] imm;
  logic [DATA_W-1:0] sub_b;
  logic              sub_bin;
  logic [DATA_W-1:0] diff;
  logic              bout, half_bout, ovf;
  logic [7:0]        sreg_next;
  logic              upd;

  cmp_decode #(.INSTR_W(INSTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .instr(instr), .op(op), .dst_idx(dst_idx), .src_idx(src_idx), .imm(imm)
  );

  assign sub_b   = (op == OP_CMPI) ? imm : rr_val;
  assign sub_bin = (op == OP_CMPC) ? sreg_in[SR_C] : 1'b0;

  cmp_sub #(.DATA_W(DATA_W)) u_sub (
    .a(rd_val), .b(sub_b), .bin(sub_bin),
    .diff(diff), .bout(bout), .half_bout(half_bout), .ovf(ovf)
  );

  cmp_flag_merge #(.DATA_W(DATA_W)) u_merge (
    .op(op), .diff(diff), .bout(bout), .half_bout(half_bout), .ovf(ovf),
    .sreg_in(sreg_in), .sreg_next(sreg_next), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_upd   <= 1'b0;
      sreg_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_upd  <= upd;
        sreg_out <= sreg_next;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(sreg_out)); // R10
  AST_TI_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> sreg_out[7:6] == $past(sreg_in[7:6])); // R8
  AST_NONCMP_KEEP: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == OP_NONE |=> sreg_out == $past(sreg_in) && !out_upd); // R9
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_upd |-> sreg_out[SR_S] == (sreg_out[SR_N] ^ sreg_out[SR_V])); // R5
  AST_PLAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == OP_CMP && rd_val == rr_val |=> sreg_out[SR_Z] && !sreg_out[SR_C]); // R6
endmodule

// File: tb/cmp_flag_unit_bench.sv
module cmp_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] instr;
  logic [7:0]  rd_val, rr_val, sreg_in;
  logic [4:0]  dst_idx, src_idx;
  logic        out_valid, out_upd;
  logic [7:0]  sreg_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cmp_flag_unit u_cmp_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rd_val(rd_val), .rr_val(rr_val), .sreg_in(sreg_in),
    .dst_idx(dst_idx), .src_idx(src_idx),
    .out_valid(out_valid), .out_upd(out_upd), .sreg_out(sreg_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 plain, 2 chained, 3 immediate
  function automatic int kind_of(input logic [15:0] w);
    if (w[15:10] == 6'b000101) return 1;
    if (w[15:10] == 6'b000001) return 2;
    if (w[15:12] == 4'b0011)   return 3;
    return 0;
  endfunction

  function automatic logic [7:0] model(input logic [15:0] w, input logic [7:0] a,
                                       input logic [7:0] b, input logic [7:0] s);
    int k = kind_of(w);
    logic [7:0] bb, r, o;
    logic [8:0] full;
    logic [4:0] lo;
    logic cin, n, v;
    if (k == 0) return s;
    bb   = (k == 3) ? {w[11:8], w[3:0]} : b;
    cin  = (k == 2) ? s[0] : 1'b0;
    full = {1'b0, a} - {1'b0, bb} - {8'd0, cin};
    lo   = {1'b0, a[3:0]} - {1'b0, bb[3:0]} - {4'd0, cin};
    r = full[7:0];
    n = r[7];
    v = (a[7] != bb[7]) && (r[7] != a[7]);
    o = s;
    o[0] = full[8];
    o[1] = (k == 2) ? ((r == 8'd0) && s[1]) : (r == 8'd0);
    o[2] = n;
    o[3] = v;
    o[4] = n ^ v;
    o[5] = lo[4];
    return o;
  endfunction

  function automatic string rtag(input logic [15:0] w);
    case (kind_of(w))
      1: return "R1/R4/R5/R6";
      2: return "R2/R4/R5/R7";
      3: return "R3/R4/R5/R6";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [15:0] w, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] s, output logic [7:0] got);
    logic [4:0] ed;
    int k = kind_of(w);
    @(negedge clk);
    in_valid = 1'b1; instr = w; rd_val = a; rr_val = b; sreg_in = s;
    #1;
    ed = (k == 3) ? {1'b1, w[7:4]} : {w[8], w[7:4]};
    if (k != 0) begin
      check("R11 dst_idx", {11'd0, dst_idx}, {11'd0, ed});
      check("R11 src_idx", {11'd0, src_idx}, {11'd0, w[9], w[3:0]});
    end
    @(posedge clk); #1;
    check("R10 out_valid", {15'd0, out_valid}, 16'd1);
    check({rtag(w), " sreg"}, {8'd0, sreg_out}, {8'd0, model(w, a, b, s)});
    check("R1/R9 out_upd", {15'd0, out_upd}, {15'd0, (k != 0)});
    check("R8 T/I", {14'd0, sreg_out[7:6]}, {14'd0, s[7:6]});
    got = sreg_out;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, hold, s1;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; instr = '0; rd_val = '0; rr_val = '0; sreg_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset valid", {15'd0, out_valid}, 16'd0);
    check("R12 reset sreg", {8'd0, sreg_out}, 16'd0);
    check("R12 reset upd", {15'd0, out_upd}, 16'd0);
    @(negedge clk); rst = 1'b0;

    // R7: 16-bit compare of equal values: plain low then chained high
    apply(16'h1401, 8'h34, 8'h34, 8'hC0, got);
    apply(16'h0401, 8'h12, 8'h12, got, got);
    check("R7 chain equal Z", {15'd0, got[1]}, 16'd1);
    check("R2 chain equal C", {15'd0, got[0]}, 16'd0);
    // 0x1200 vs 0x1201: borrow from low byte and Z stays clear
    apply(16'h1401, 8'h00, 8'h01, 8'h00, got);
    apply(16'h0401, 8'h12, 8'h12, got, got);
    check("R7 chain borrow Z", {15'd0, got[1]}, 16'd0);
    check("R2 chain borrow C", {15'd0, got[0]}, 16'd1);
    // R7: zero difference with incoming Z clear keeps Z clear
    apply(16'h0401, 8'h55, 8'h55, 8'h00, got);
    check("R7 zero keeps clear", {15'd0, got[1]}, 16'd0);
    // R4: 0x00 - 0xFF sets C and H
    apply(16'h1401, 8'h00, 8'hFF, 8'h00, got);
    check("R4 carry/half", {14'd0, got[5], got[0]}, 16'd3);
    // R5: 0x80 - 0x01 overflows
    apply(16'h1401, 8'h80, 8'h01, 8'h00, got);
    check("R5 overflow", {13'd0, got[4], got[3], got[2]}, 16'b110);
    // R3: immediate 0xA5 against register value 0xA5, decoy rr_val
    apply(16'h3A55, 8'hA5, 8'h00, 8'h00, got);
    check("R3 immediate equal Z", {15'd0, got[1]}, 16'd1);
    // R9: non-compare word leaves the status byte
    apply(16'h9508, 8'h00, 8'h01, 8'h5A, got);
    check("R9 passthrough", {8'd0, got}, 16'h005A);

    // R10: no strobe and held output while idle
    hold = sreg_out;
    @(negedge clk); in_valid = 1'b0; sreg_in = 8'hFF; instr = 16'h1401;
    @(posedge clk); #1;
    check("R10 idle valid", {15'd0, out_valid}, 16'd0);
    check("R10 idle hold", {8'd0, sreg_out}, {8'd0, hold});

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      int sel = $urandom_range(0, 3);
      w = 16'($urandom);
      case (sel)
        0: w[15:10] = 6'b000101;
        1: w[15:10] = 6'b000001;
        2: w[15:12] = 4'b0011;
        default: ;
      endcase
      s1 = 8'($urandom);
      apply(w, 8'($urandom), 8'($urandom), s1, got);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule